// File: doc/BRIEF.md
# Comparator Edge Event Requester

This block turns transitions of an already-filtered comparator output into service requests. It compares the input with a copy registered one clock earlier. A rising or a falling transition sets its own sticky flag, and that flag stays set until something clears it.

Each flag has its own enable. When an enabled flag is pending, the block raises one of two outputs. Normally this is a processor interrupt. When the DMA enable is set, the same event becomes a DMA request instead. In DMA mode, the controller's completion pulse clears the enabled flags. The request then drops and the block is ready for the next edge. Software can also clear either flag with a write-one-to-clear pulse. Register decoding and the DMA engine sit outside this block.

Top module: `cmp_evt_requester`

## Requirements
- R1: A synchronous active-high reset clears both flags, both request outputs and the stored reference level to 0. A high input held through reset and then released low sets no flag.
- R2: On a clock edge where `cmp_out` is 1 and the stored reference is 0, `flag_rise` becomes 1. It stays 1 on later cycles until it is cleared.
- R3: On a clock edge where `cmp_out` is 0 and the stored reference is 1, `flag_fall` becomes 1. `flag_rise` does not change.
- R4: A one-cycle pulse on `clr_rise` or `clr_fall` clears the matching flag at the next clock edge. If the same edge also detects that flag's transition, the flag stays set.
- R5: While `dma_en` is 0, `irq` is 1 exactly when (`ie_rise` and `flag_rise`) or (`ie_fall` and `flag_fall`). A flag that was set while its enable was 0 raises `irq` once the enable goes to 1.
- R6: `irq` and `dma_req` fall to 0 once no enable/flag pair is both set, whether the enable or the flag went away.
- R7: While `dma_en` is 1, `irq` is held at 0 and `dma_req` takes the level that `irq` would otherwise have. The two outputs are never 1 together.
- R8: A `dma_done` pulse while `dma_en` is 1 clears, at the next edge, each flag whose enable is 1. Flags whose enable is 0 stay set. `dma_req` then drops, and a later enabled edge raises it again.
- R9: A `dma_done` pulse while `dma_en` is 0 changes no flag and no output.
- R10: If `dma_done` coincides with a newly detected transition of an enabled flag, that flag stays set and `dma_req` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_out | input | 1 | Filtered comparator level, synchronous to `clk` |
| ie_rise | input | 1 | Rising-event request enable |
| ie_fall | input | 1 | Falling-event request enable |
| dma_en | input | 1 | Routes events to `dma_req` instead of `irq` |
| clr_rise | input | 1 | Write-one-to-clear pulse for the rising flag |
| clr_fall | input | 1 | Write-one-to-clear pulse for the falling flag |
| dma_done | input | 1 | Completion pulse from the DMA controller |
| flag_rise | output | 1 | Sticky rising-transition flag |
| flag_fall | output | 1 | Sticky falling-transition flag |
| irq | output | 1 | Processor interrupt request |
| dma_req | output | 1 | DMA transfer request |

## Verification
The assertions assume the following about the inputs:
- `cmp_out`, the enables and all pulses are already synchronous to `clk`.
- They carry no X once reset is released.
- `dma_done` and the clear strobes are single-cycle pulses.

The directed stimulus changes every input on the falling clock edge. It keeps each clear and completion strobe high for exactly one cycle. It checks outputs on the next falling edge, after the single register stage has updated. It also times a completion pulse to land on the same edge as a fresh transition, to exercise the set-wins rule.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
    localparam int NUM_KINDS = 2;
    localparam int KIND_RISE = 0;
    localparam int KIND_FALL = 1;

    typedef logic [NUM_KINDS-1:0] kind_vec_t;

    typedef struct packed {
        logic ref_lvl;
    } edge_st_t;

    typedef struct packed {
        logic pend;
    } flag_st_t;
endpackage

// File: rtl/cmp_evt_edge.sv
module cmp_evt_edge
    import cmp_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    output kind_vec_t evt
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ref_lvl = level;
        evt          = '0;
        evt[KIND_RISE] = level & ~st_q.ref_lvl;
        evt[KIND_FALL] = ~level & st_q.ref_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    ref_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> st_q.ref_lvl == $past(level));
endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr_sw,
    input  logic clr_dma,
    output logic pend
);
    import cmp_evt_pkg::*;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_sw || clr_dma) st_d.pend = 1'b0;
        if (set)               st_d.pend = 1'b1;
        pend = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    // R4 / R8
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_sw || clr_dma) && !set |=> !pend);

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !set && !clr_sw && !clr_dma |=> pend == $past(pend));
endmodule

// File: rtl/cmp_evt_req.sv
module cmp_evt_req
    import cmp_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  kind_vec_t flags,
    input  kind_vec_t ie,
    input  logic      dma_en,
    input  logic      dma_done,
    output logic      irq,
    output logic      dma_req,
    output kind_vec_t dma_clr
);
    kind_vec_t hit;

    always_comb begin
        hit     = flags & ie;
        irq     = !dma_en && (|hit);
        dma_req = dma_en && (|hit);
        dma_clr = (dma_en && dma_done) ? ie : '0;
    end

    // R7
    no_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq && dma_req));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        dma_en |-> !irq);

    // R6
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (flags & ie) == '0 |-> !irq && !dma_req);
endmodule

// File: rtl/cmp_evt_requester.sv
module cmp_evt_requester
    import cmp_evt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmp_out,
    input  logic ie_rise,
    input  logic ie_fall,
    input  logic dma_en,
    input  logic clr_rise,
    input  logic clr_fall,
    input  logic dma_done,
    output logic flag_rise,
    output logic flag_fall,
    output logic irq,
    output logic dma_req
);
    kind_vec_t evt, flags, ie_vec, clr_vec, dma_clr;

    always_comb begin
        ie_vec            = '0;
        clr_vec           = '0;
        ie_vec[KIND_RISE]  = ie_rise;
        ie_vec[KIND_FALL]  = ie_fall;
        clr_vec[KIND_RISE] = clr_rise;
        clr_vec[KIND_FALL] = clr_fall;
    end

    cmp_evt_edge edge_i (
        .clk   (clk),
        .rst   (rst),
        .level (cmp_out),
        .evt   (evt)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_flag
        cmp_evt_flag flag_i (
            .clk     (clk),
            .rst     (rst),
            .set     (evt[k]),
            .clr_sw  (clr_vec[k]),
            .clr_dma (dma_clr[k]),
            .pend    (flags[k])
        );
    end

    cmp_evt_req req_i (
        .clk      (clk),
        .rst      (rst),
        .flags    (flags),
        .ie       (ie_vec),
        .dma_en   (dma_en),
        .dma_done (dma_done),
        .irq      (irq),
        .dma_req  (dma_req),
        .dma_clr  (dma_clr)
    );

    assign flag_rise = flags[KIND_RISE];
    assign flag_fall = flags[KIND_FALL];

    // R10
    done_vs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        dma_done && dma_en && ie_rise && evt[KIND_RISE] |=> flag_rise && dma_req);
endmodule

// File: tb/cmp_evt_requester_tb.sv
`timescale 1ns/1ps
module cmp_evt_requester_tb_top;
    logic clk = 1'b0;
    logic rst, cmp_out, ie_rise, ie_fall, dma_en, clr_rise, clr_fall, dma_done;
    logic flag_rise, flag_fall, irq, dma_req;
    int   vec = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    cmp_evt_requester dut_i (
        .clk(clk), .rst(rst), .cmp_out(cmp_out), .ie_rise(ie_rise), .ie_fall(ie_fall),
        .dma_en(dma_en), .clr_rise(clr_rise), .clr_fall(clr_fall), .dma_done(dma_done),
        .flag_rise(flag_rise), .flag_fall(flag_fall), .irq(irq), .dma_req(dma_req)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic pulse_clr_rise();
        clr_rise = 1'b1; tick(); clr_rise = 1'b0;
    endtask

    task automatic pulse_clr_fall();
        clr_fall = 1'b1; tick(); clr_fall = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cmp_out = 1'b1;
        repeat (3) tick();
        chk("R1", "flag_rise in reset", flag_rise, 1'b0);
        chk("R1", "flag_fall in reset", flag_fall, 1'b0);
        chk("R1", "irq in reset", irq, 1'b0);
        chk("R1", "dma_req in reset", dma_req, 1'b0);
        cmp_out = 1'b0;
        tick();
        rst = 1'b0;
        tick(); tick();
        chk("R1", "no fall after reset", flag_fall, 1'b0);
        chk("R1", "no rise after reset", flag_rise, 1'b0);
    endtask

    task automatic t_rise();
        cmp_out = 1'b1; tick();
        chk("R2", "rise flag set", flag_rise, 1'b1);
        chk("R2", "fall flag untouched", flag_fall, 1'b0);
        chk("R5", "irq off while disabled", irq, 1'b0);
        tick(); tick();
        chk("R2", "rise flag sticky", flag_rise, 1'b1);
        ie_rise = 1'b1; tick();
        chk("R5", "irq from late enable", irq, 1'b1);
        ie_rise = 1'b0; tick();
        chk("R6", "irq drops with enable", irq, 1'b0);
        ie_rise = 1'b1; pulse_clr_rise();
        chk("R4", "rise flag cleared", flag_rise, 1'b0);
        chk("R6", "irq drops with flag", irq, 1'b0);
        ie_rise = 1'b0;
    endtask

    task automatic t_fall();
        cmp_out = 1'b0; tick();
        chk("R3", "fall flag set", flag_fall, 1'b1);
        chk("R3", "rise flag untouched", flag_rise, 1'b0);
        ie_fall = 1'b1; tick();
        chk("R5", "irq from fall", irq, 1'b1);
        pulse_clr_fall();
        chk("R4", "fall flag cleared", flag_fall, 1'b0);
        chk("R6", "irq drops after fall clear", irq, 1'b0);
        ie_fall = 1'b0;
    endtask

    task automatic t_set_wins();
        cmp_out = 1'b1; clr_rise = 1'b1; tick(); clr_rise = 1'b0;
        chk("R4", "set wins over clear", flag_rise, 1'b1);
        pulse_clr_rise();
        chk("R4", "later clear works", flag_rise, 1'b0);
    endtask

    task automatic t_dma();
        dma_en = 1'b1; ie_rise = 1'b1;
        cmp_out = 1'b0; tick();
        chk("R7", "disabled fall gives no dma_req", dma_req, 1'b0);
        pulse_clr_fall();
        cmp_out = 1'b1; tick();
        chk("R7", "dma_req raised", dma_req, 1'b1);
        chk("R7", "irq held low", irq, 1'b0);
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk("R8", "done clears rise flag", flag_rise, 1'b0);
        chk("R8", "done drops dma_req", dma_req, 1'b0);
        cmp_out = 1'b0; tick();
        cmp_out = 1'b1; tick();
        chk("R8", "re-armed dma_req", dma_req, 1'b1);
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk("R8", "enabled flag cleared", flag_rise, 1'b0);
        chk("R8", "disabled flag kept", flag_fall, 1'b1);
        pulse_clr_fall();
        ie_rise = 1'b0; dma_en = 1'b0;
    endtask

    task automatic t_done_ignored();
        cmp_out = 1'b0; tick();
        ie_fall = 1'b1; tick();
        chk("R9", "irq before done", irq, 1'b1);
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk("R9", "flag kept without dma_en", flag_fall, 1'b1);
        chk("R9", "irq kept without dma_en", irq, 1'b1);
        chk("R9", "no dma_req", dma_req, 1'b0);
        pulse_clr_fall();
        ie_fall = 1'b0;
    endtask

    task automatic t_done_vs_edge();
        dma_en = 1'b1; ie_fall = 1'b1;
        cmp_out = 1'b1; tick();
        cmp_out = 1'b0; dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk("R10", "fall flag kept", flag_fall, 1'b1);
        chk("R10", "dma_req kept", dma_req, 1'b1);
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        chk("R8", "plain done clears fall", flag_fall, 1'b0);
        chk("R8", "dma_req released", dma_req, 1'b0);
        pulse_clr_rise();
        dma_en = 1'b0; ie_fall = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cmp_out = 1'b0; ie_rise = 1'b0; ie_fall = 1'b0; dma_en = 1'b0;
        clr_rise = 1'b0; clr_fall = 1'b0; dma_done = 1'b0;
        tick();
        t_reset();
        t_rise();
        t_fall();
        t_set_wins();
        t_dma();
        t_done_ignored();
        t_done_vs_edge();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog: requirement all, actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule